// File: doc/BRIEF.md
# Serial EEPROM Read/Write Sequencer

This block drives a serial EEPROM over a four-wire SPI link on behalf of a simple host request port. The host gives an offset, a byte count and a direction in one cycle. The block then runs the whole transfer without further host action. It pulls write bytes one at a time through a take strobe, and it returns read bytes as one-cycle pulses. When the transfer ends it gives one completion pulse with a byte count and an error flag.

A read is one chip-select frame. A write is split into pieces that never cross a device page. Each piece is framed by a write-enable command before it and by status polling after it. Polling goes on until the device reports ready, or until a minimum number of polls has been made and a millisecond deadline has passed, whichever comes last. The address length (one, two or three bytes) is fixed at elaboration, and the serial clock comes from a plain divider.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: A read request produces exactly one chip-select frame holding opcode 0x03, the address, and then the clipped byte count of data clocked in back to back. Each byte appears as an rd_valid pulse, in address order.
- R2: Every address is sent as ADDR_BYTES bytes, most significant byte first, right after the opcode. Serial data uses SPI mode 0: MOSI changes while SCLK is low, MISO is sampled on the rising SCLK edge, and each byte goes MSB first.
- R3: If the request offset is at or above DEV_SIZE, no frame is issued. A read then completes with resp_len 0 and resp_err 0; a write completes with resp_len 0 and resp_err 1. A zero count completes with resp_len 0 and resp_err 0.
- R4: When offset plus count runs past DEV_SIZE, the transfer is cut to DEV_SIZE minus offset bytes, and resp_len reports that number on success.
- R5: Each write piece carries min(PAGE_SIZE - (offset mod PAGE_SIZE), remaining) bytes. The next piece starts at the offset that follows.
- R6: Each write piece is preceded by a separate one-byte frame holding 0x06. The piece frame itself is 0x02, the address, and then the data bytes taken from wr_data in order.
- R7: After each piece the block sends frames of opcode 0x05 plus one dummy byte, reading the status byte each time. It moves on only when bit 0 (write in progress) reads 0.
- R8: While bit 0 reads 1, polling continues as long as fewer than MIN_POLLS polls have been made, or fewer than CLK_KHZ*TIMEOUT_MS cycles have passed since the piece frame ended. Otherwise the transfer stops with a timeout.
- R9: On a timeout, resp_len gives the bytes of fully completed pieces. resp_err is 1 only when that count is 0.
- R10: Chip select is high whenever no frame is in progress. SCLK is low and still whenever chip select is high. Chip select stays high for at least 2*SCK_HALF clock cycles between frames.
- R11: busy is high from request acceptance to the done pulse, and done pulses for exactly one cycle. A request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8*ADDR_BYTES | Starting byte offset |
| req_count | input | CNT_W | Requested byte count |
| wr_data | input | 8 | Next write byte, held until taken |
| wr_take | output | 1 | Pulse: wr_data was consumed |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Pulse: rd_data is valid |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Pulse: transfer finished |
| resp_len | output | CNT_W | Bytes transferred, valid with done |
| resp_err | output | 1 | Failure with nothing transferred, valid with done |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bound checker watches the cycle-level rules on every clock. These are: chip select and clock idle together, the clock toggling only inside a frame, write bytes taken only inside a frame, single-cycle completion, and an error completion that reports no bytes. The sequencing itself can only be shown by the bench's device model: page splitting, the write-enable frame before each piece, the status-poll count at the retry floor and past the deadline, clipping at the device end, and partial counts after a timeout. The model decodes every frame and logs piece lengths, poll counts and protocol errors, and the bench compares these with values worked out from the request.

// File: rtl/eeprom_spi_pkg.sv
package eeprom_spi_pkg;
  localparam logic [7:0] CMD_WR_ENABLE = 8'h06;
  localparam logic [7:0] CMD_STATUS    = 8'h05;
  localparam logic [7:0] CMD_READ      = 8'h03;
  localparam logic [7:0] CMD_WRITE     = 8'h02;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_WREN, S_SEG, S_ADDR, S_DATA,
    S_POLL_OP, S_POLL_RD, S_GAP, S_FIN
  } seq_state_t;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int HALF = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  localparam int DIV_W = $clog2(HALF) + 1;

  logic             active;
  logic [DIV_W-1:0] div;
  logic [2:0]       bitn;
  logic [7:0]       sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      div    <= '0;
      bitn   <= '0;
      sh     <= '0;
      rx     <= '0;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          sh     <= tx;
          mosi   <= tx[7];
          div    <= '0;
          bitn   <= '0;
          sclk   <= 1'b0;
        end
      end else if (div == DIV_W'(HALF - 1)) begin
        div <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
            sh   <= {sh[6:0], 1'b0};
            mosi <= sh[6];
          end
        end
      end else begin
        div <= div + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/eeprom_seg_calc.sv
module eeprom_seg_calc #(
  parameter int PAGE  = 64,
  parameter int CNT_W = 16,
  localparam int PW   = $clog2(PAGE)
) (
  input  logic [PW-1:0]    off_low,
  input  logic [CNT_W-1:0] remain,
  output logic [CNT_W-1:0] seg
);
  logic [CNT_W:0] room;

  always_comb begin
    room = (CNT_W+1)'(PAGE) - (CNT_W+1)'(off_low);
    seg  = (room > {1'b0, remain}) ? remain : room[CNT_W-1:0];
  end
endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import eeprom_spi_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  parameter int DEV_SIZE   = 32768,
  parameter int PAGE_SIZE  = 64,
  parameter int CNT_W      = 16,
  parameter int SCK_HALF   = 4,
  parameter int CLK_KHZ    = 125000,
  parameter int TIMEOUT_MS = 25,
  parameter int MIN_POLLS  = 3,
  localparam int OFF_W     = 8 * ADDR_BYTES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [OFF_W-1:0] req_offset,
  input  logic [CNT_W-1:0] req_count,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] resp_len,
  output logic             resp_err,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             spi_cs_n
);
  localparam int TO_CYC  = CLK_KHZ * TIMEOUT_MS;
  localparam int TO_W    = $clog2(TO_CYC + 1);
  localparam int GAP_CYC = 2 * SCK_HALF;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);
  localparam int PC_W    = $clog2(MIN_POLLS + 1) + 1;
  localparam int PW      = $clog2(PAGE_SIZE);

  seq_state_t       st, gap_nx;
  logic             is_wr, fail, stat_ph;
  logic [OFF_W-1:0] off;
  logic [CNT_W-1:0] rem, total, wrote, seg, seg_left, seg_w;
  logic [1:0]       aleft;
  logic [PC_W-1:0]  polls;
  logic [TO_W-1:0]  timer;
  logic [GAP_W-1:0] gap_cnt;
  logic             eng_go, eng_done;
  logic [7:0]       eng_tx, eng_rx;

  logic [31:0] space32, clip32;
  logic [1:0]  aidx;
  logic [7:0]  addr_byte;

  always_comb begin
    space32   = 32'(DEV_SIZE) - 32'(req_offset);
    clip32    = (32'(req_count) > space32) ? space32 : 32'(req_count);
    aidx      = aleft - 2'd1;
    addr_byte = 8'(off >> {aidx, 3'b000});
  end

  eeprom_seg_calc #(.PAGE(PAGE_SIZE), .CNT_W(CNT_W)) u_seg (
    .off_low(off[PW-1:0]), .remain(rem), .seg(seg_w)
  );

  spi_byte_shifter #(.HALF(SCK_HALF)) u_shift (
    .clk(clk), .rst(rst), .go(eng_go), .tx(eng_tx), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .done(eng_done), .rx(eng_rx)
  );

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;  gap_nx <= S_IDLE;
      is_wr <= 1'b0; fail <= 1'b0; stat_ph <= 1'b0;
      off <= '0; rem <= '0; total <= '0; wrote <= '0;
      seg <= '0; seg_left <= '0; aleft <= '0;
      polls <= '0; timer <= '0; gap_cnt <= '0;
      eng_go <= 1'b0; eng_tx <= '0;
      wr_take <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
      done <= 1'b0; resp_len <= '0; resp_err <= 1'b0;
      spi_cs_n <= 1'b1;
    end else begin
      eng_go   <= 1'b0;
      wr_take  <= 1'b0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
      if (timer != TO_W'(TO_CYC)) timer <= timer + TO_W'(1);
      case (st)
        S_IDLE: if (req_valid) begin
          is_wr <= req_write;
          off   <= req_offset;
          wrote <= '0;
          fail  <= 1'b0;
          if (32'(req_offset) >= 32'(DEV_SIZE)) begin
            fail  <= req_write;
            total <= '0;
            st    <= S_FIN;
          end else if (req_count == '0) begin
            total <= '0;
            st    <= S_FIN;
          end else begin
            rem   <= CNT_W'(clip32);
            total <= CNT_W'(clip32);
            st    <= S_START;
          end
        end
        S_START: begin
          spi_cs_n <= 1'b0;
          eng_go   <= 1'b1;
          aleft    <= 2'(ADDR_BYTES);
          seg_left <= rem;
          eng_tx   <= is_wr ? CMD_WR_ENABLE : CMD_READ;
          st       <= is_wr ? S_WREN : S_ADDR;
        end
        S_WREN: if (eng_done) begin
          spi_cs_n <= 1'b1;
          gap_nx   <= S_SEG;
          st       <= S_GAP;
        end
        S_SEG: begin
          spi_cs_n <= 1'b0;
          eng_go   <= 1'b1;
          eng_tx   <= CMD_WRITE;
          seg      <= seg_w;
          seg_left <= seg_w;
          aleft    <= 2'(ADDR_BYTES);
          st       <= S_ADDR;
        end
        S_ADDR: if (eng_done) begin
          eng_go <= 1'b1;
          if (aleft != 2'd0) begin
            eng_tx <= addr_byte;
            aleft  <= aidx;
          end else begin
            eng_tx  <= is_wr ? wr_data : 8'h00;
            wr_take <= is_wr;
            st      <= S_DATA;
          end
        end
        S_DATA: if (eng_done) begin
          if (!is_wr) begin
            rd_valid <= 1'b1;
            rd_data  <= eng_rx;
          end
          seg_left <= seg_left - CNT_W'(1);
          if (seg_left == CNT_W'(1)) begin
            spi_cs_n <= 1'b1;
            st       <= S_GAP;
            gap_nx   <= is_wr ? S_POLL_OP : S_FIN;
            polls    <= '0;
            timer    <= '0;
          end else begin
            eng_go  <= 1'b1;
            eng_tx  <= is_wr ? wr_data : 8'h00;
            wr_take <= is_wr;
          end
        end
        S_POLL_OP: begin
          spi_cs_n <= 1'b0;
          eng_go   <= 1'b1;
          eng_tx   <= CMD_STATUS;
          stat_ph  <= 1'b0;
          st       <= S_POLL_RD;
        end
        S_POLL_RD: if (eng_done) begin
          if (!stat_ph) begin
            stat_ph <= 1'b1;
            eng_go  <= 1'b1;
            eng_tx  <= 8'h00;
          end else begin
            spi_cs_n <= 1'b1;
            st       <= S_GAP;
            if (polls != PC_W'(MIN_POLLS)) polls <= polls + PC_W'(1);
            if (!eng_rx[0]) begin
              wrote  <= wrote + seg;
              off    <= off + OFF_W'(seg);
              rem    <= rem - seg;
              gap_nx <= (rem == seg) ? S_FIN : S_START;
            end else if ((polls + PC_W'(1) < PC_W'(MIN_POLLS)) ||
                         (timer < TO_W'(TO_CYC))) begin
              gap_nx <= S_POLL_OP;
            end else begin
              fail   <= 1'b1;
              gap_nx <= S_FIN;
            end
          end
        end
        S_GAP: begin
          if (gap_cnt == GAP_W'(GAP_CYC - 1)) begin
            gap_cnt <= '0;
            st      <= gap_nx;
          end else begin
            gap_cnt <= gap_cnt + GAP_W'(1);
          end
        end
        S_FIN: begin
          done     <= 1'b1;
          resp_len <= is_wr ? wrote : total;
          resp_err <= fail && (wrote == '0);
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_eeprom_ctrl_chk.sv
module spi_eeprom_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] resp_len,
  input logic             resp_err,
  input logic             rd_valid,
  input logic             wr_take,
  input logic             spi_cs_n,
  input logic             spi_sclk
);
  a_r10_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

  a_r10_sclk_moves_only_in_frame: assert property (@(posedge clk) disable iff (rst)
    !$stable(spi_sclk) |-> !spi_cs_n);

  a_r11_idle_is_deselected: assert property (@(posedge clk) disable iff (rst)
    !busy |-> spi_cs_n);

  a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r11_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));

  a_r9_error_has_no_bytes: assert property (@(posedge clk) disable iff (rst)
    (done && resp_err) |-> (resp_len == '0));

  a_r6_take_inside_frame: assert property (@(posedge clk) disable iff (rst)
    wr_take |-> (!spi_cs_n && busy));

  a_r1_read_byte_while_busy: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> busy);
endmodule

bind spi_eeprom_ctrl spi_eeprom_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .resp_len(resp_len),
  .resp_err(resp_err), .rd_valid(rd_valid), .wr_take(wr_take),
  .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk)
);

// File: tb/spi_eeprom_ctrl_tb.sv
module spi_eeprom_ctrl_tb;
  localparam int AB = 2, DEV = 512, PAGE = 16, HALF = 2;
  localparam int GAP = 2 * HALF;

  typedef struct packed {
    logic        wr;
    logic [15:0] off;
    logic [15:0] cnt;
    logic [7:0]  b0;
    logic [7:0]  br;
    logic [15:0] len;
    logic        err;
    logic [15:0] sent;
    logic [7:0]  polls;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VT [NV] = '{
    '{1'b1, 16'd5,   16'd20, 8'd1, 8'd1, 16'd20, 1'b0, 16'd20, 8'd4},
    '{1'b1, 16'd32,  16'd16, 8'd0, 8'd0, 16'd16, 1'b0, 16'd16, 8'd1},
    '{1'b1, 16'd500, 16'd30, 8'd2, 8'd2, 16'd12, 1'b0, 16'd12, 8'd3},
    '{1'b1, 16'd512, 16'd4,  8'd0, 8'd0, 16'd0,  1'b1, 16'd0,  8'd0},
    '{1'b0, 16'd5,   16'd20, 8'd0, 8'd0, 16'd20, 1'b0, 16'd0,  8'd0},
    '{1'b0, 16'd505, 16'd10, 8'd0, 8'd0, 16'd7,  1'b0, 16'd0,  8'd0},
    '{1'b0, 16'd600, 16'd3,  8'd0, 8'd0, 16'd0,  1'b0, 16'd0,  8'd0},
    '{1'b1, 16'd60,  16'd40, 8'd3, 8'd3, 16'd0,  1'b1, 16'd4,  8'd3},
    '{1'b1, 16'd100, 16'd0,  8'd0, 8'd0, 16'd0,  1'b0, 16'd0,  8'd0},
    '{1'b0, 16'd56,  16'd12, 8'd0, 8'd0, 16'd12, 1'b0, 16'd0,  8'd0},
    '{1'b1, 16'd200, 16'd20, 8'd0, 8'd3, 16'd8,  1'b0, 16'd20, 8'd4},
    '{1'b0, 16'd195, 16'd30, 8'd0, 8'd0, 16'd30, 1'b0, 16'd0,  8'd0},
    '{1'b0, 16'd500, 16'd12, 8'd0, 8'd0, 16'd12, 1'b0, 16'd0,  8'd0}
  };

  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_offset = '0, req_count = '0;
  logic [7:0]  wr_data, rd_data;
  logic        wr_take, rd_valid, busy, done, resp_err;
  logic [15:0] resp_len;
  logic        spi_sclk, spi_mosi, spi_cs_n;
  logic        spi_miso = 1'b0;

  always #4 clk = ~clk;

  spi_eeprom_ctrl #(
    .ADDR_BYTES(AB), .DEV_SIZE(DEV), .PAGE_SIZE(PAGE), .CNT_W(16),
    .SCK_HALF(HALF), .CLK_KHZ(2), .TIMEOUT_MS(20), .MIN_POLLS(3)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_count(req_count), .wr_data(wr_data),
    .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
    .done(done), .resp_len(resp_len), .resp_err(resp_err),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] wpat(input int v, input int j);
    return 8'(v * 37 + j * 5 + 1);
  endfunction

  // host side data
  int vid = 0, wbase = 0, widx = 0, rcnt = 0, ndone = 0;
  logic [7:0] rbuf [4096];
  assign wr_data = wpat(vid, widx - wbase);
  always @(negedge clk) begin
    if (wr_take) widx++;
    if (rd_valid) begin rbuf[rcnt % 4096] = rd_data; rcnt++; end
    if (done) ndone++;
  end

  // device model
  logic [7:0] mem [DEV];
  logic [7:0] exp_mem [DEV];
  int busy0 = 0, busyr = 0, xid = 0;
  int frm_id = 0;
  int m_last_frm = 0, m_bits = 0, m_nb = 0, m_op = 0, m_addr = 0;
  int m_dcnt = 0, m_wbase = 0, stat_reads = 0;
  logic [7:0] m_sh = '0, m_nxt = '0;
  int end_last = 0, wel = 0, proto_err = 0, nseg = 0, wren_frames = 0;
  int read_frames = 0, seg_x = -1, segs_in_x = 0, busy_tgt = 0, stat_mark = 0;
  int seg_log [1024];
  int gap_cyc = 0, min_gap = 1000;

  initial for (int i = 0; i < DEV; i++) begin
    mem[i] = 8'(i) ^ 8'hA5;
    exp_mem[i] = 8'(i) ^ 8'hA5;
  end

  always @(negedge spi_cs_n) frm_id++;

  always @(posedge clk) begin
    if (spi_cs_n === 1'b1) gap_cyc++;
    else begin
      if (gap_cyc > 0 && gap_cyc < min_gap) min_gap = gap_cyc;
      gap_cyc = 0;
    end
  end

  always @(posedge spi_sclk) if (spi_cs_n === 1'b0) begin
    if (m_last_frm != frm_id) begin
      m_last_frm = frm_id; m_bits = 0; m_nb = 0; m_dcnt = 0;
    end
    m_sh = {m_sh[6:0], spi_mosi};
    m_bits++;
    if (m_bits == 8) begin
      m_bits = 0;
      if (m_nb == 0) begin
        m_op = m_sh; m_addr = 0;
        if (m_sh == 8'h05) begin
          m_nxt = ((stat_reads - stat_mark) < busy_tgt) ? 8'h03 : 8'h00;
          stat_reads++;
        end
      end else if (m_nb <= AB) begin
        m_addr = (m_addr << 8) | m_sh;
        if (m_nb == AB && m_op == 3) begin m_nxt = mem[m_addr % DEV]; m_addr++; end
      end else begin
        if (m_op == 3) begin m_nxt = mem[m_addr % DEV]; m_addr++; end
        if (m_op == 2) begin
          if (m_dcnt == 0) m_wbase = m_addr;
          if (wel != 0)
            mem[((m_wbase / PAGE) * PAGE + ((m_wbase + m_dcnt) % PAGE)) % DEV] = m_sh;
          m_dcnt++;
        end
      end
      m_nb++;
    end
  end

  always @(negedge spi_sclk) if (spi_cs_n === 1'b0) spi_miso = m_nxt[7 - m_bits];

  always @(posedge spi_cs_n) if (frm_id > 0 && end_last != frm_id) begin
    end_last = frm_id;
    if (m_op == 6) begin
      if (m_nb == 1) begin wel = 1; wren_frames++; end
      else proto_err++;
    end else if (m_op == 2) begin
      if (wel == 0) proto_err++;
      if ((m_wbase % PAGE) + m_dcnt > PAGE) proto_err++;
      seg_log[nseg % 1024] = m_dcnt; nseg++;
      wel = 0;
      if (seg_x != xid) begin seg_x = xid; segs_in_x = 0; end
      busy_tgt = (segs_in_x == 0) ? busy0 : busyr;
      segs_in_x++;
      stat_mark = stat_reads;
    end else if (m_op == 3) read_frames++;
  end

  // one request, waits for done
  task automatic run_req(input logic wr, input int off, input int cnt, input int v,
                         output int len, output bit err);
    @(negedge clk);
    vid = v; wbase = widx; xid++;
    req_valid = 1'b1; req_write = wr;
    req_offset = 16'(off); req_count = 16'(cnt);
    @(negedge clk);
    req_valid = 1'b0;
    while (done !== 1'b1) @(negedge clk);
    len = resp_len; err = resp_err;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int len, r0, s0, w0, st0, p0, f0, o, rr, k, nexp, sg;
    bit err, dok;
    string rq;
    repeat (5) @(negedge clk);
    // R11 R10 reset state
    chk(busy === 1'b0 && done === 1'b0, "R11 reset idle", busy, 0);
    chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R10 reset deselected", spi_cs_n, 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      busy0 = VT[i].b0; busyr = VT[i].br;
      r0 = rcnt; s0 = nseg; w0 = wren_frames; st0 = stat_reads; p0 = proto_err; f0 = read_frames;
      run_req(VT[i].wr, VT[i].off, VT[i].cnt, i, len, err);
      rq = (VT[i].off >= DEV) ? "R3" : (VT[i].err || VT[i].sent != VT[i].len) ? "R9" : "R4";
      chk(len == VT[i].len, {rq, " len"}, len, VT[i].len);
      chk(err == VT[i].err, {rq, " err"}, err, VT[i].err);
      if (VT[i].wr) begin
        for (int j = 0; j < VT[i].sent; j++) exp_mem[VT[i].off + j] = wpat(i, j);
        // R5: expected piece lengths over the bytes sent
        o = VT[i].off; rr = VT[i].sent; k = 0; dok = 1;
        while (rr > 0) begin
          sg = PAGE - (o % PAGE); if (sg > rr) sg = rr;
          if (s0 + k >= nseg || seg_log[(s0 + k) % 1024] != sg) dok = 0;
          o += sg; rr -= sg; k++;
        end
        nexp = k;
        chk(dok && (nseg - s0) == nexp, "R5 pieces", nseg - s0, nexp);
        chk((wren_frames - w0) == nexp && proto_err == p0, "R6 enable per piece",
            wren_frames - w0, nexp);
        chk((stat_reads - st0) == VT[i].polls,
            (VT[i].polls >= 3 && VT[i].err | (VT[i].sent != VT[i].len)) ? "R8 polls" : "R7 polls",
            stat_reads - st0, VT[i].polls);
      end else begin
        dok = (rcnt - r0) == len;
        for (int j = 0; j < len; j++)
          if (rbuf[(r0 + j) % 4096] !== exp_mem[VT[i].off + j]) dok = 0;
        chk(dok, "R1 R2 read data", rcnt - r0, len);
        chk((read_frames - f0) == ((len > 0) ? 1 : 0), "R1 one frame",
            read_frames - f0, (len > 0) ? 1 : 0);
      end
    end

    // R11: request while busy is ignored
    busy0 = 0; busyr = 0;
    r0 = rcnt; f0 = read_frames; k = ndone;
    @(negedge clk);
    vid = 40; wbase = widx; xid++;
    req_valid = 1'b1; req_write = 1'b1; req_offset = 16'd300; req_count = 16'd3;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (60) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_offset = 16'd0; req_count = 16'd5;
    @(negedge clk);
    req_valid = 1'b0;
    while (done !== 1'b1) @(negedge clk);
    chk(resp_len == 16'd3 && resp_err == 1'b0, "R11 first request kept", resp_len, 3);
    repeat (400) @(negedge clk);
    chk((ndone - k) == 1, "R11 no second transfer", ndone - k, 1);
    chk((rcnt - r0) == 0 && (read_frames - f0) == 0, "R11 no read issued", rcnt - r0, 0);

    // R10 deselect gap
    chk(min_gap >= GAP, "R10 deselect gap", min_gap, GAP);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule